// File: doc/BRIEF.md
# Clock Device Two-Wire Configuration Slave

This block is the serial control port of a clock generator. A host on a two-wire bus (SCL, SDA) addresses the slave, sends a command byte, and then either writes or reads eight 8-bit control registers. A set bit 7 in the command selects indexed access to one register, whose index sits in bits 4:0. A clear bit 7 selects sequential access that always begins at register 0 and carries a byte count. Bits 6:5 of the command act as a chip-select and must be zero. A read is always the second half of a combined transaction: the host writes the command, issues a repeated start, and then sends the read address.

The block runs entirely in a fast system clock domain. It synchronizes both bus lines and oversamples them. It detects start and stop conditions and bus clock edges, and it pulls SDA low through an open-drain enable when it acknowledges or sends a zero bit. The register contents drive six control bits for the clock outputs: two output enables, spread enable, spread amount, test mode entry and test output select.

Top module: `clkcfg_twi_slave`

## Requirements
- R1: After reset, the registers hold 0x7C, 0x00, 0xEB, 0xAF, 0x01, 0x00, 0x13 and 0x01 for indices 0 to 7. The control outputs are out_en_a=1, out_en_b=1, spread_sel=1, spread_en=0, test_mode=0 and test_sel=0, and SDA is released.
- R2: The slave acknowledges the write address byte 0xD2 (7-bit address 0x69, R/W=0). It does not acknowledge any other address and ignores the rest of that transaction.
- R3: A command byte whose bits 6:5 are not 00 is not acknowledged, and the transaction that follows changes no register.
- R4: A command with bit 7 = 1 and bits 4:0 = n, followed by one data byte, writes that byte into register n.
- R5: After a command with bit 7 = 1, a repeated start and the read address 0xD3, the slave returns register n most significant bit first. It changes SDA only while SCL is low.
- R6: A block write (command 0x00) takes a count byte, then stores data bytes into registers 0, 1, 2 and so on. Every byte is acknowledged. Bytes past the count, or past the last register, are discarded. A stop after any complete byte leaves the registers that were not reached unchanged.
- R7: A block read (command 0x00, repeated start, 0xD3) returns the count 8 and then registers 0 to 7 in order, until the host answers with a NACK.
- R8: Register 7 is read-only and always reads 0x01: revision 0 in bits 7:4 and vendor code 1 in bits 3:0.
- R9: A byte write to an index above 7 changes nothing. A byte read of such an index returns 0x00.
- R10: A read address that is not preceded by a command in the same transaction is not acknowledged.
- R11: A block command (bit 7 = 0) with nonzero bits 4:0 is not acknowledged.
- R12: The control outputs follow the registers. out_en_a is register 0 bit 3, out_en_b is register 0 bit 4, spread_en is register 2 bit 2, spread_sel is register 2 bit 7, test_mode is register 6 bit 6, and test_sel is register 6 bit 7. They change only when a write reaches those registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_drive_low | output | 1 | Open-drain enable; 1 pulls SDA low |
| out_en_a | output | 1 | Enable for the first clock output pair |
| out_en_b | output | 1 | Enable for the second clock output pair |
| spread_en | output | 1 | Spread modulation on |
| spread_sel | output | 1 | Spread amount: 0 smaller, 1 larger down-spread |
| test_mode | output | 1 | Test clock mode entry |
| test_sel | output | 1 | In test mode: 1 divided reference, 0 high impedance |

## Verification
The bench builds the block with its defaults: two synchronizer stages, eight registers and address 0x69. Each bus quarter-period lasts ten system clocks, so SCL is sampled about forty times per bit. At that rate the synchronizer delay of three to four cycles stays well inside each SCL low phase. The eight-register default also lets a single block transfer run past the last writable index and the read-only index, and a five-bit command offset reaches the unmapped indices above 7.

// File: rtl/clkcfg_pkg.sv
// Package: shared constants, the state type and register reset values
// for the clock-configuration two-wire slave.
package clkcfg_pkg;

    localparam int unsigned IDX_W = 5;            // width of the command offset field

    // Control field placement (decoded by the clock outputs downstream).
    localparam int unsigned OE_REG       = 0;
    localparam int unsigned OE_A_BIT     = 3;
    localparam int unsigned OE_B_BIT     = 4;
    localparam int unsigned SPREAD_REG   = 2;
    localparam int unsigned SPR_EN_BIT   = 2;
    localparam int unsigned SPR_SEL_BIT  = 7;
    localparam int unsigned TEST_REG     = 6;
    localparam int unsigned TST_MODE_BIT = 6;
    localparam int unsigned TST_SEL_BIT  = 7;

    localparam logic [3:0] REVISION_CODE = 4'h0;
    localparam logic [3:0] VENDOR_CODE   = 4'h1;

    typedef enum logic [2:0] {
        ST_IDLE,    // bus free
        ST_ADDR,    // receiving address byte
        ST_CMD,     // receiving command byte
        ST_COUNT,   // receiving block-write count
        ST_WDATA,   // receiving data bytes
        ST_TX,      // sending bytes to the host
        ST_WAIT     // not addressed; wait for start or stop
    } twi_state_e;

    // Reset value of register idx; the last one is the identity byte.
    function automatic logic [7:0] reg_default(int unsigned idx);
        case (idx)
            0:       return 8'h7C;
            2:       return 8'hEB;
            3:       return 8'hAF;
            4:       return 8'h01;
            6:       return 8'h13;
            7:       return {REVISION_CODE, VENDOR_CODE};
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
// Module: twi_line_sync
// Brings SCL and SDA into the system clock domain through a parameterized
// flip-flop chain. It then flags SCL edges and start/stop conditions, each
// as a one-cycle pulse.
// Assumes the system clock oversamples SCL by at least 16x, so that one
// SCL level lasts many system cycles.
module twi_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_q;

    // Synchronizer chains; the idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
        end else begin
            scl_chain <= {scl_chain[STAGES-2:0], scl_raw};
            sda_chain <= {sda_chain[STAGES-2:0], sda_raw};
        end
    end

    assign scl_q = scl_chain[STAGES-1];
    assign sda_q = sda_chain[STAGES-1];

    // One-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_q;
            sda_prev <= sda_q;
        end
    end

    assign scl_rise  = scl_q & ~scl_prev;
    assign scl_fall  = ~scl_q & scl_prev;
    assign start_det = scl_q & scl_prev & sda_prev & ~sda_q;
    assign stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;

endmodule

// File: rtl/twi_slave_fsm.sv
// Module: twi_slave_fsm
// Byte-level protocol engine. It matches the address, decodes the command
// (single/block, chip-select, offset), takes the block count, issues
// register writes and serializes read bytes. It drives SDA low for
// acknowledges and zero bits, and changes the drive only on SCL falling edges.
// Assumes line events come from twi_line_sync and that rd_data is a
// combinational function of rd_idx.
module twi_slave_fsm
    import clkcfg_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h69,
    parameter int unsigned NREGS    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_q,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             sda_low,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [7:0]       rd_data
);
    localparam logic [7:0] COUNT_BYTE = 8'(NREGS);

    twi_state_e       state;
    twi_state_e       ret_state;
    logic [3:0]       bit_cnt;
    logic [7:0]       sh;
    logic             ack_ph;
    logic             blk;
    logic             cmd_ok;
    logic             cnt_pend;
    logic             m_nack;
    logic [IDX_W-1:0] wptr;
    logic [IDX_W-1:0] rptr;
    logic [7:0]       wleft;
    logic [7:0]       tx_byte;

    // Pointer advance that sticks at the top of the offset range.
    function automatic logic [IDX_W-1:0] sat_inc(logic [IDX_W-1:0] x);
        return (x == '1) ? x : x + 1'b1;
    endfunction

    assign rd_idx  = rptr;
    assign tx_byte = cnt_pend ? COUNT_BYTE : rd_data;

    // Protocol sequencing, bit shifting and register write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            ret_state <= ST_IDLE;
            bit_cnt   <= '0;
            sh        <= '0;
            ack_ph    <= 1'b0;
            blk       <= 1'b0;
            cmd_ok    <= 1'b0;
            cnt_pend  <= 1'b0;
            m_nack    <= 1'b0;
            wptr      <= '0;
            rptr      <= '0;
            wleft     <= '0;
            sda_low   <= 1'b0;
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                state   <= ST_IDLE;
                cmd_ok  <= 1'b0;
                ack_ph  <= 1'b0;
                sda_low <= 1'b0;
            end else if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                ack_ph  <= 1'b0;
                sda_low <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_CMD, ST_COUNT, ST_WDATA: begin
                        if (!ack_ph) begin
                            if (scl_rise) begin
                                sh      <= {sh[6:0], sda_q};
                                bit_cnt <= bit_cnt + 1'b1;
                            end else if (scl_fall && bit_cnt == 4'd8) begin
                                ack_ph <= 1'b1;
                                case (state)
                                    ST_ADDR: begin
                                        if (sh[7:1] == DEV_ADDR && !sh[0]) begin
                                            sda_low   <= 1'b1;
                                            ret_state <= ST_CMD;
                                        end else if (sh[7:1] == DEV_ADDR && cmd_ok) begin
                                            sda_low   <= 1'b1;
                                            ret_state <= ST_TX;
                                            cnt_pend  <= blk;
                                        end else begin
                                            ret_state <= ST_WAIT;
                                        end
                                    end
                                    ST_CMD: begin
                                        if (sh[6:5] != 2'b00 ||
                                            (!sh[7] && sh[4:0] != 5'd0)) begin
                                            ret_state <= ST_WAIT;
                                        end else begin
                                            sda_low   <= 1'b1;
                                            blk       <= ~sh[7];
                                            cmd_ok    <= 1'b1;
                                            rptr      <= sh[IDX_W-1:0];
                                            wptr      <= sh[IDX_W-1:0];
                                            wleft     <= 8'd1;
                                            ret_state <= sh[7] ? ST_WDATA : ST_COUNT;
                                        end
                                    end
                                    ST_COUNT: begin
                                        sda_low   <= 1'b1;
                                        wleft     <= sh;
                                        wptr      <= '0;
                                        ret_state <= ST_WDATA;
                                    end
                                    default: begin
                                        sda_low   <= 1'b1;
                                        ret_state <= ST_WDATA;
                                        if (wleft != 8'd0) begin
                                            wr_en   <= 1'b1;
                                            wr_idx  <= wptr;
                                            wr_data <= sh;
                                            wleft   <= wleft - 1'b1;
                                            wptr    <= sat_inc(wptr);
                                        end
                                    end
                                endcase
                            end
                        end else if (scl_fall) begin
                            ack_ph  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ret_state;
                            if (ret_state == ST_TX) begin
                                sh      <= tx_byte;
                                sda_low <= ~tx_byte[7];
                                if (cnt_pend) cnt_pend <= 1'b0;
                                else          rptr     <= sat_inc(rptr);
                            end else begin
                                sda_low <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (!ack_ph) begin
                            if (scl_rise) begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end else if (scl_fall) begin
                                if (bit_cnt == 4'd8) begin
                                    sda_low <= 1'b0;
                                    ack_ph  <= 1'b1;
                                end else begin
                                    sh      <= {sh[6:0], 1'b0};
                                    sda_low <= ~sh[6];
                                end
                            end
                        end else begin
                            if (scl_rise) begin
                                m_nack <= sda_q;
                            end else if (scl_fall) begin
                                ack_ph  <= 1'b0;
                                bit_cnt <= '0;
                                if (m_nack) begin
                                    state <= ST_WAIT;
                                end else begin
                                    sh      <= tx_byte;
                                    sda_low <= ~tx_byte[7];
                                    if (cnt_pend) cnt_pend <= 1'b0;
                                    else          rptr     <= sat_inc(rptr);
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/clkcfg_regbank.sv
// Module: clkcfg_regbank
// Control register array with reset defaults. The last register holds a
// constant identity byte. Writes to that register or to any index past the
// array are dropped; reads past the array return zero. It also decodes
// the six control bits.
// Assumes one write strobe per cycle from the protocol engine.
module clkcfg_regbank
    import clkcfg_pkg::*;
#(
    parameter int unsigned NREGS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             out_en_a,
    output logic             out_en_b,
    output logic             spread_en,
    output logic             spread_sel,
    output logic             test_mode,
    output logic             test_sel
);
    localparam int unsigned AW = $clog2(NREGS);

    logic [NREGS-1:0][7:0] regs;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (g == NREGS - 1) begin : g_ro
            assign regs[g] = reg_default(g);
        end else begin : g_rw
            logic [7:0] q;
            // Writable register with its reset default.
            always_ff @(posedge clk) begin
                if (!rst_n)                                q <= reg_default(g);
                else if (wr_en && wr_idx == IDX_W'(g))     q <= wr_data;
            end
            assign regs[g] = q;
        end
    end

    // Read mux with zero fill beyond the array.
    always_comb begin
        rd_data = 8'h00;
        if (rd_idx < IDX_W'(NREGS)) rd_data = regs[rd_idx[AW-1:0]];
    end

    assign out_en_a   = regs[OE_REG][OE_A_BIT];
    assign out_en_b   = regs[OE_REG][OE_B_BIT];
    assign spread_en  = regs[SPREAD_REG][SPR_EN_BIT];
    assign spread_sel = regs[SPREAD_REG][SPR_SEL_BIT];
    assign test_mode  = regs[TEST_REG][TST_MODE_BIT];
    assign test_sel   = regs[TEST_REG][TST_SEL_BIT];

endmodule

// File: rtl/clkcfg_twi_slave.sv
// Module: clkcfg_twi_slave (top)
// Two-wire configuration slave for a clock device: line synchronizer,
// protocol engine and control register bank.
// Assumes an external open-drain pad: sda_drive_low pulls SDA low, and
// sda_in carries the resolved wire level.
module clkcfg_twi_slave
    import clkcfg_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h69,
    parameter int unsigned NREGS       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_drive_low,
    output logic out_en_a,
    output logic out_en_b,
    output logic spread_en,
    output logic spread_sel,
    output logic test_mode,
    output logic test_sel
);
    logic             sda_q;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;

    twi_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_in),
        .sda_raw   (sda_in),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_slave_fsm #(.DEV_ADDR(DEV_ADDR), .NREGS(NREGS)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_low   (sda_drive_low),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data)
    );

    clkcfg_regbank #(.NREGS(NREGS)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .out_en_a   (out_en_a),
        .out_en_b   (out_en_b),
        .spread_en  (spread_en),
        .spread_sel (spread_sel),
        .test_mode  (test_mode),
        .test_sel   (test_sel)
    );

endmodule

// File: rtl/clkcfg_twi_checker.sv
// Module: clkcfg_twi_checker
// Temporal checks on the configuration slave. It is attached to every
// instance of the top module by the bind at the end of this file.
module clkcfg_twi_checker
    import clkcfg_pkg::*;
#(
    parameter int unsigned NREGS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_in,
    input logic             sda_drive_low,
    input logic             stop_det,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic             out_en_a,
    input logic             out_en_b,
    input logic             spread_en,
    input logic             spread_sel,
    input logic             test_mode,
    input logic             test_sel
);
    logic [5:0] ctrl;
    assign ctrl = {out_en_a, out_en_b, spread_en, spread_sel, test_mode, test_sel};

    // R1: defaults present on the first cycle out of reset
    a_r1_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ctrl == 6'b110100 && !sda_drive_low));

    // R2: a stop always releases the data line
    a_r2_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_drive_low);

    // R5: the slave starts pulling SDA only while SCL is low
    a_r5_drive_in_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_in);

    // R12: control outputs move only on a write strobe
    a_r12_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl));

    // R9: writes to the identity or unmapped indices leave controls untouched
    a_r9_high_index_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= IDX_W'(NREGS - 1)) |=> $stable(ctrl));

endmodule

bind clkcfg_twi_slave clkcfg_twi_checker #(.NREGS(NREGS)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_in        (scl_in),
    .sda_drive_low (sda_drive_low),
    .stop_det      (stop_det),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .out_en_a      (out_en_a),
    .out_en_b      (out_en_b),
    .spread_en     (spread_en),
    .spread_sel    (spread_sel),
    .test_mode     (test_mode),
    .test_sel      (test_sel)
);

// File: tb/test_clkcfg_twi_slave.sv
// Bench: a bus master model drives the slave. A vector table of byte
// writes and readbacks runs first, followed by directed cases.
module test_clkcfg_twi_slave;
    localparam int Q = 10;   // system clocks per quarter bus period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_bus;
    logic sda_drive_low, out_en_a, out_en_b, spread_en, spread_sel, test_mode, test_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] mdl [8];
    logic [7:0] wbuf [16];

    // {command, write data, expected readback}
    localparam logic [23:0] VEC [8] = '{
        24'h805555, 24'h828484, 24'h86C0C0, 24'h87AA01,
        24'h893300, 24'h830000, 24'h81FFFF, 24'h855A5A
    };

    always #2.5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_drive_low;

    clkcfg_twi_slave i_clkcfg_twi_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_drive_low(sda_drive_low), .out_en_a(out_en_a), .out_en_b(out_en_b),
        .spread_en(spread_en), .spread_sel(spread_sel),
        .test_mode(test_mode), .test_sel(test_sel)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        ack = ~a;
    endtask

    task automatic recv_byte(input logic ack_it, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        put_bit(~ack_it);
    endtask

    task automatic byte_write(input logic [7:0] cmd, input logic [7:0] d, output logic all_ack);
        logic a1, a2, a3;
        bus_start(); send_byte(8'hD2, a1); send_byte(cmd, a2); send_byte(d, a3); bus_stop();
        all_ack = a1 & a2 & a3;
    endtask

    task automatic byte_read(input logic [7:0] cmd, output logic [7:0] d, output logic all_ack);
        logic a1, a2, a3;
        bus_start(); send_byte(8'hD2, a1); send_byte(cmd, a2);
        bus_start(); send_byte(8'hD3, a3); recv_byte(1'b0, d); bus_stop();
        all_ack = a1 & a2 & a3;
    endtask

    // Block write of n bytes from wbuf, with count byte cnt.
    task automatic blk_write(input logic [7:0] cnt, input int n, input string req);
        logic a;
        bus_start();
        send_byte(8'hD2, a); chk(req, a, 1'b1);
        send_byte(8'h00, a); chk(req, a, 1'b1);
        send_byte(cnt, a);   chk(req, a, 1'b1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); chk(req, a, 1'b1);
        end
        bus_stop();
    endtask

    // Block read of the whole bank, compared with the bench model.
    task automatic blk_read_check(input string req);
        logic a1, a2, a3;
        logic [7:0] v;
        bus_start(); send_byte(8'hD2, a1); send_byte(8'h00, a2);
        bus_start(); send_byte(8'hD3, a3);
        chk(req, {a1, a2, a3}, 3'b111);
        recv_byte(1'b1, v); chk({req, " count (R7)"}, v, 8'h08);
        for (int i = 0; i < 8; i++) begin
            recv_byte(i != 7, v); chk(req, v, mdl[i]);
        end
        bus_stop();
    endtask

    task automatic set_defaults();
        mdl = '{8'h7C, 8'h00, 8'hEB, 8'hAF, 8'h01, 8'h00, 8'h13, 8'h01};
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(5); rst_n = 1'b1; tick(2);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic ok;
        logic a;
        logic [7:0] v;
        set_defaults();
        do_reset();

        // R1: reset state at the pins
        chk("R1 controls", {out_en_a, out_en_b, spread_en, spread_sel, test_mode, test_sel}, 6'b110100);
        chk("R1 sda released", sda_drive_low, 1'b0);
        // R1, R7: defaults through a block read
        blk_read_check("R1 R7 default readback");

        // R4, R5, R8, R9: table of byte writes and readbacks
        foreach (VEC[k]) begin
            byte_write(VEC[k][23:16], VEC[k][15:8], ok);
            chk("R4 write acks", ok, 1'b1);
            byte_read(VEC[k][23:16], v, ok);
            chk("R5 read acks", ok, 1'b1);
            chk("R4 R5 R8 R9 readback", v, VEC[k][7:0]);
        end
        mdl = '{8'h55, 8'hFF, 8'h84, 8'h00, 8'h01, 8'h5A, 8'hC0, 8'h01};

        // R12: reg0=55, reg2=84, reg6=C0
        chk("R12 controls", {out_en_a, out_en_b, spread_en, spread_sel, test_mode, test_sel}, 6'b011111);

        // R2: foreign address is refused and the transaction is ignored
        bus_start(); send_byte(8'hA0, a); chk("R2 foreign address nack", a, 1'b0);
        send_byte(8'h80, a); send_byte(8'h11, a); bus_stop();
        byte_read(8'h80, v, ok); chk("R2 no effect", v, 8'h55);

        // R3: chip-select field 01 refused, nothing written
        bus_start(); send_byte(8'hD2, a); chk("R3 address ack", a, 1'b1);
        send_byte(8'hA0, a); chk("R3 command nack", a, 1'b0);
        send_byte(8'h22, a); bus_stop();
        byte_read(8'h80, v, ok); chk("R3 no write", v, 8'h55);

        // R11: block command with nonzero offset refused
        bus_start(); send_byte(8'hD2, a); send_byte(8'h02, a);
        chk("R11 block offset nack", a, 1'b0); bus_stop();

        // R10: read address without a command first
        bus_start(); send_byte(8'hD3, a); chk("R10 bare read nack", a, 1'b0); bus_stop();

        // R6: count 3 with 4 bytes; the fourth is acknowledged but dropped
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        blk_write(8'd3, 4, "R6 block write acks");
        mdl[0] = 8'h11; mdl[1] = 8'h22; mdl[2] = 8'h33;
        blk_read_check("R6 count limit");

        // R6, R8: count 10 runs past the last register
        for (int i = 0; i < 9; i++) wbuf[i] = 8'hA0 + 8'(i);
        blk_write(8'd10, 9, "R6 long block acks");
        for (int i = 0; i < 7; i++) mdl[i] = 8'hA0 + 8'(i);
        blk_read_check("R6 R8 long block");

        // R6: stop after two of five bytes
        wbuf[0] = 8'hB0; wbuf[1] = 8'hB1;
        blk_write(8'd5, 2, "R6 early stop acks");
        mdl[0] = 8'hB0; mdl[1] = 8'hB1;
        blk_read_check("R6 early stop");

        // R12: reg0=B0, reg2=A2, reg6=A6
        chk("R12 controls after block", {out_en_a, out_en_b, spread_en, spread_sel, test_mode, test_sel}, 6'b010101);

        // R1: reset again restores defaults
        do_reset();
        chk("R1 controls after reset", {out_en_a, out_en_b, spread_en, spread_sel, test_mode, test_sel}, 6'b110100);
        set_defaults();
        blk_read_check("R1 readback after reset");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule